// File: doc/BRIEF.md
# I2C Master Transmit Queue

This block sits between the register bus of an I2C master and the bit-level SDA/SCL driver that the master shares with its other engines. Software enables the queue and writes payload bytes into it one register write at a time. The engine takes the oldest byte and streams it MSB first, one bit request per bit. It then requests a ninth, released bit and reads the level the slave drives there. A low level is an acknowledge and the engine moves on to the next queued byte at once. A high level is a refusal, and the engine stops there.

Running out of bytes after an acknowledge and being refused by the slave are reported as two separate interrupt causes. Each cause has its own sticky status bit and its own enable. After a refusal the remaining bytes stay queued and untouched until software writes the self-clearing flush bit. START and STOP conditions and the receive path belong to other blocks.

Register map (3-bit address, 8-bit data): 0 control, 1 data push, 2 status (write 1 to clear), 3 interrupt enable, 4 queue status.

Top module: `i2c_txf_engine`

## Requirements
- R1: After reset, control (address 0) reads 0x00, status (address 2) reads 0x00, queue status (address 4) reads 0x10, and irq_o and bit_req_o are low.
- R2: A write to address 1 while control bit 6 (enable) is 1 queues its byte. While enable is 0 such a write changes nothing: nothing is queued, nothing is sent and no flag is set. Control bit 6 reads back the written enable value.
- R3: The queue holds FIFO_DEPTH bytes, and queue status bit 5 reads 1 when it is full. A push to a full queue is dropped and sets the sticky status bit 2.
- R4: Each byte is sent in write order as 8 bit requests, MSB first, followed by a ninth request with bit_o high. bit_req_o and bit_o hold steady until bit_ack_i. sda_i low at the ninth acknowledge means ACK.
- R5: When a byte ends with ACK and more bytes are queued, the request for the next byte rises on the clock edge after the ACK.
- R6: An ACK on a byte that leaves the queue empty sets status bit 1. Queue status bit 4 reads 1 only when no byte is queued or in flight.
- R7: sda_i high at the ninth acknowledge sets status bit 0 and control bit 3.
- R8: While control bit 3 is set, no new bit request is issued and the queued bytes are kept, so queue status bit 4 stays 0.
- R9: Writing control with bit 7 set reads back bit 7 as 1 for exactly one cycle. On the next edge the queue empties and control bit 3 clears, and none of the discarded bytes is ever sent.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: irq_o is high exactly when status bit 0 is set with enable bit 0 (address 3), or status bit 1 is set with enable bit 1. A cause whose enable is 0 never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| bit_req_o | output | 1 | Bit request to the shared line driver |
| bit_o | output | 1 | Bit to drive, 1 = release SDA |
| bit_ack_i | input | 1 | One-cycle completion of the requested bit |
| sda_i | input | 1 | SDA level sampled by the driver, valid with bit_ack_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the engine at its default depth of 64 bytes. This makes overflow a push to a full 64-entry queue, and the bench fills the queue while the engine is halted by a refusal so that no byte drains out during the fill. The line driver model answers each bit request after two cycles. This leaves room to check that the request and bit hold steady, and that the next byte starts on the edge right after an ACK. A behavioural queue model predicts the request, the bit value and the interrupt line on every cycle, including flushes that land while bytes are still queued.

// File: rtl/i2c_txf_pkg.sv
package i2c_txf_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_DATA  = 3'd1,
    RA_STAT  = 3'd2,
    RA_IEN   = 3'd3,
    RA_QSTAT = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_HALT_BIT  = 3;
  localparam int unsigned CTRL_EN_BIT    = 6;
  localparam int unsigned CTRL_FLUSH_BIT = 7;
  localparam int unsigned ST_NAK_BIT     = 0;
  localparam int unsigned ST_EMPTY_BIT   = 1;
  localparam int unsigned ST_OVF_BIT     = 2;
  localparam int unsigned QS_EMPTY_BIT   = 4;
  localparam int unsigned QS_FULL_BIT    = 5;
  localparam int unsigned N_CAUSE        = 2;
  localparam int unsigned N_STAT         = 3;
endpackage

// File: rtl/i2c_txf_fifo.sv
module i2c_txf_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
endmodule

// File: rtl/i2c_txf_shifter.sv
module i2c_txf_shifter #(
  parameter int unsigned DW = 8,
  localparam int unsigned CNTW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          bit_req_o,
  output logic          bit_o,
  input  logic          bit_ack_i,
  input  logic          sda_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          nak_o
);
  logic            busy_q;
  logic [DW-1:0]   sh_q;
  logic [CNTW-1:0] cnt_q;
  logic            ack_slot;

  assign ack_slot = (cnt_q == CNTW'(DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sh_q   <= data_i;
        cnt_q  <= '0;
      end
    end else if (bit_ack_i) begin
      if (ack_slot) begin
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q + CNTW'(1);
      end
    end
  end

  // ninth slot releases SDA so the slave can answer
  assign bit_o     = ack_slot ? 1'b1 : sh_q[DW-1];
  assign bit_req_o = busy_q;
  assign busy_o    = busy_q;
  assign done_o    = busy_q && bit_ack_i && ack_slot;
  assign nak_o     = sda_i;
endmodule

// File: rtl/i2c_txf_regs.sv
module i2c_txf_regs
  import i2c_txf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic                ctrl_wr_i,
  input  logic                en_val_i,
  input  logic                flush_val_i,
  input  logic                stat_wr_i,
  input  logic [N_STAT-1:0]   stat_clr_i,
  input  logic                ien_wr_i,
  input  logic [N_CAUSE-1:0]  ien_val_i,
  input  logic                ev_nak_i,
  input  logic                ev_empty_i,
  input  logic                ev_ovf_i,
  input  logic                drained_i,
  input  logic                full_i,
  output logic                en_o,
  output logic                flush_o,
  output logic                halt_o,
  output logic [N_STAT-1:0]   stat_o,
  output logic [REG_DW-1:0]   rdata_o,
  output logic                irq_o
);
  logic               en_q, flush_q, halt_q;
  logic [N_CAUSE-1:0] ien_q;
  logic [N_STAT-1:0]  st_q, st_set;

  assign st_set = {ev_ovf_i, ev_empty_i, ev_nak_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      halt_q  <= 1'b0;
      ien_q   <= '0;
      st_q    <= '0;
    end else begin
      flush_q <= ctrl_wr_i && flush_val_i;
      if (ctrl_wr_i) en_q  <= en_val_i;
      if (ien_wr_i)  ien_q <= ien_val_i;
      if (ev_nak_i)     halt_q <= 1'b1;
      else if (flush_q) halt_q <= 1'b0;
      // a new event in the clear cycle wins
      st_q <= (st_q & ~(stat_wr_i ? stat_clr_i : '0)) | st_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_CTRL: begin
        rdata_o[CTRL_FLUSH_BIT] = flush_q;
        rdata_o[CTRL_EN_BIT]    = en_q;
        rdata_o[CTRL_HALT_BIT]  = halt_q;
      end
      RA_STAT:  rdata_o[N_STAT-1:0]  = st_q;
      RA_IEN:   rdata_o[N_CAUSE-1:0] = ien_q;
      RA_QSTAT: begin
        rdata_o[QS_EMPTY_BIT] = drained_i;
        rdata_o[QS_FULL_BIT]  = full_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign flush_o = flush_q;
  assign halt_o  = halt_q;
  assign stat_o  = st_q;
  assign irq_o   = |(st_q[N_CAUSE-1:0] & ien_q);
endmodule

// File: rtl/i2c_txf_engine.sv
module i2c_txf_engine
  import i2c_txf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              bit_req_o,
  output logic              bit_o,
  input  logic              bit_ack_i,
  input  logic              sda_i,
  output logic              irq_o
);
  logic              wr_ctrl, wr_data, wr_stat, wr_ien;
  logic              en, flush, halt;
  logic [N_STAT-1:0] stat;
  logic              push, pop, full, empty, ovf;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     fifo_cnt;
  logic              busy, tx_done, tx_nak;
  logic              ev_nak, ev_empty, drained;

  assign wr_ctrl = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_data = reg_we_i && (reg_addr_i == RA_DATA);
  assign wr_stat = reg_we_i && (reg_addr_i == RA_STAT);
  assign wr_ien  = reg_we_i && (reg_addr_i == RA_IEN);

  assign push = wr_data && en && !flush && !full;
  assign ovf  = wr_data && en && !flush && full;
  assign pop  = en && !halt && !busy && !empty && !flush;

  assign ev_nak   = tx_done && tx_nak;
  assign ev_empty = tx_done && !tx_nak && empty;
  assign drained  = empty && !busy;

  i2c_txf_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (flush),
    .push_i  (push),
    .data_i  (reg_wdata_i[BYTE_W-1:0]),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .count_o (fifo_cnt)
  );

  i2c_txf_shifter #(.DW(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (pop),
    .data_i    (head),
    .bit_req_o (bit_req_o),
    .bit_o     (bit_o),
    .bit_ack_i (bit_ack_i),
    .sda_i     (sda_i),
    .busy_o    (busy),
    .done_o    (tx_done),
    .nak_o     (tx_nak)
  );

  i2c_txf_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (reg_addr_i),
    .ctrl_wr_i   (wr_ctrl),
    .en_val_i    (reg_wdata_i[CTRL_EN_BIT]),
    .flush_val_i (reg_wdata_i[CTRL_FLUSH_BIT]),
    .stat_wr_i   (wr_stat),
    .stat_clr_i  (reg_wdata_i[N_STAT-1:0]),
    .ien_wr_i    (wr_ien),
    .ien_val_i   (reg_wdata_i[N_CAUSE-1:0]),
    .ev_nak_i    (ev_nak),
    .ev_empty_i  (ev_empty),
    .ev_ovf_i    (ovf),
    .drained_i   (drained),
    .full_i      (full),
    .en_o        (en),
    .flush_o     (flush),
    .halt_o      (halt),
    .stat_o      (stat),
    .rdata_o     (reg_rdata_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/i2c_txf_engine_chk.sv
module i2c_txf_engine_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_req_o,
  input logic          bit_o,
  input logic          bit_ack_i,
  input logic          irq_o,
  input logic [CW-1:0] fifo_cnt,
  input logic          halt,
  input logic          flush,
  input logic          busy,
  input logic          tx_done,
  input logic          tx_nak,
  input logic [2:0]    stat
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  assert_bit_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o && !bit_ack_i |=> bit_req_o && $stable(bit_o));

  assert_empty_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done && !tx_nak && (fifo_cnt == '0) |=> stat[1]);

  assert_nak_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done && tx_nak |=> halt && stat[0]);

  assert_halt_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt && !busy |=> !bit_req_o);

  assert_flush_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !flush && (fifo_cnt == '0));

  assert_irq_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat[0] || stat[1]));
endmodule

bind i2c_txf_engine i2c_txf_engine_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_req_o (bit_req_o),
  .bit_o     (bit_o),
  .bit_ack_i (bit_ack_i),
  .irq_o     (irq_o),
  .fifo_cnt  (fifo_cnt),
  .halt      (halt),
  .flush     (flush),
  .busy      (busy),
  .tx_done   (tx_done),
  .tx_nak    (tx_nak),
  .stat      (stat)
);

// File: tb/i2c_txf_engine_tb.sv
`timescale 1ns/1ps
module i2c_txf_engine_tb;
  localparam int DEPTH = 64;
  localparam int LAT   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       bit_req, bit_v, irq;
  logic       bit_ack = 1'b0;
  logic       sda = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_txf_engine #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bit_req_o(bit_req),
    .bit_o(bit_v), .bit_ack_i(bit_ack), .sda_i(sda), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // line driver model
  int   lat = 0;
  int   slot = 0;
  bit   nak_next = 0;
  logic [7:0] rx_sh = 8'd0;
  logic [7:0] rx_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_ack) begin
        bit_ack <= 1'b0;
        lat = 0;
      end else if (bit_req) begin
        lat++;
        if (lat == LAT) begin
          bit_ack <= 1'b1;
          if (slot == 8) begin
            sda <= nak_next;
            nak_next = 0;
            rx_q.push_back(rx_sh);
            slot = 0;
          end else begin
            sda <= 1'b0;
            rx_sh = {rx_sh[6:0], bit_v};
            slot++;
          end
        end
      end
    end
  end

  // behavioural reference
  logic [7:0] m_q[$];
  logic [7:0] m_cur;
  bit   m_en, m_flush, m_halt, m_busy;
  int   m_cnt;
  logic [2:0] m_st;
  logic [1:0] m_ien;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_en = 0; m_flush = 0; m_halt = 0; m_busy = 0; m_cnt = 0;
      m_st = 3'b0; m_ien = 2'b0; m_cur = 8'd0;
    end else begin
      int  pre;
      bit  ack_done, nk, start, evemp, wd, ovf;
      pre      = m_q.size();
      ack_done = m_busy && bit_ack && (m_cnt == 8);
      nk       = sda;
      start    = m_en && !m_halt && !m_busy && (pre > 0) && !m_flush;
      evemp    = ack_done && !nk && (pre == 0);
      wd       = reg_we && (reg_addr == 3'd1) && m_en && !m_flush;
      ovf      = 0;
      if (m_busy && bit_ack) begin
        if (m_cnt == 8) m_busy = 0; else m_cnt++;
      end
      if (start) begin
        m_cur = m_q.pop_front(); m_busy = 1; m_cnt = 0;
      end
      if (m_flush) m_q.delete();
      if (wd) begin
        if (pre < DEPTH) m_q.push_back(reg_wdata); else ovf = 1;
      end
      if (ack_done && nk) m_halt = 1; else if (m_flush) m_halt = 0;
      if (reg_we && reg_addr == 3'd2) m_st = m_st & ~reg_wdata[2:0];
      m_st = m_st | {ovf, evemp, ack_done && nk};
      if (reg_we && reg_addr == 3'd3) m_ien = reg_wdata[1:0];
      m_flush = reg_we && (reg_addr == 3'd0) && reg_wdata[7];
      if (reg_we && reg_addr == 3'd0) m_en = reg_wdata[6];
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(bit_req == m_busy, "R5 bit request timing", int'(bit_req), int'(m_busy));
      if (m_busy) begin
        logic e;
        e = (m_cnt < 8) ? m_cur[7 - m_cnt] : 1'b1;
        chk(bit_v == e, "R4 bit value", int'(bit_v), int'(e));
      end
      chk(irq == |(m_st[1:0] & m_ien), "R11 irq line", int'(irq), int'(|(m_st[1:0] & m_ien)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [7:0] d);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic wait_drained();
    logic [7:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, d);
      if (d[4]) return;
    end
    chk(1'b0, "R6 drain timeout", 0, 1);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) return;
    end
    chk(1'b0, "R7 irq timeout", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk(d == 8'h00, "R1 ctrl reset", d, 8'h00);
    rd(3'd2, d); chk(d == 8'h00, "R1 status reset", d, 8'h00);
    rd(3'd4, d); chk(d == 8'h10, "R1 queue status reset", d, 8'h10);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(bit_req == 1'b0, "R1 request reset", bit_req, 0);

    // R2 push ignored while disabled
    wr(3'd1, 8'h55);
    repeat (10) begin
      @(negedge clk); chk(bit_req == 1'b0, "R2 no send when disabled", bit_req, 0);
    end
    rd(3'd4, d); chk(d == 8'h10, "R2 queue unchanged when disabled", d, 8'h10);
    rd(3'd2, d); chk(d == 8'h00, "R2 no flag when disabled", d, 8'h00);

    wr(3'd3, 8'h03);
    wr(3'd0, 8'h40);
    rd(3'd0, d); chk(d == 8'h40, "R2 enable readback", d, 8'h40);

    // R4 R5 R6 ordered stream with ACK
    wr(3'd1, 8'hA5); wr(3'd1, 8'h3C); wr(3'd1, 8'h81);
    wait_drained();
    chk(rx_q.size() == 3, "R4 byte count", rx_q.size(), 3);
    if (rx_q.size() == 3) begin
      chk(rx_q[0] == 8'hA5, "R4 byte 0", rx_q[0], 8'hA5);
      chk(rx_q[1] == 8'h3C, "R4 byte 1", rx_q[1], 8'h3C);
      chk(rx_q[2] == 8'h81, "R4 byte 2", rx_q[2], 8'h81);
    end
    rd(3'd2, d); chk(d == 8'h02, "R6 empty status", d, 8'h02);
    chk(irq == 1'b1, "R11 empty irq", irq, 1);
    wr(3'd2, 8'h00);
    rd(3'd2, d); chk(d == 8'h02, "R10 write 0 keeps", d, 8'h02);
    wr(3'd2, 8'h02);
    rd(3'd2, d); chk(d == 8'h00, "R10 write 1 clears", d, 8'h00);
    chk(irq == 1'b0, "R11 irq after clear", irq, 0);

    // R7 R8 refusal halts
    rx_q.delete();
    nak_next = 1;
    wr(3'd1, 8'h11); wr(3'd1, 8'h22); wr(3'd1, 8'h33); wr(3'd1, 8'h44);
    wait_irq();
    rd(3'd2, d); chk(d[0] == 1'b1, "R7 nak status", d, 8'h01);
    rd(3'd0, d); chk(d == 8'h48, "R7 ctrl halt bit", d, 8'h48);
    repeat (60) begin
      @(negedge clk); chk(bit_req == 1'b0, "R8 halted no request", bit_req, 0);
    end
    rd(3'd4, d); chk(d[4] == 1'b0, "R8 bytes kept", d, 8'h00);

    // R9 flush
    wr(3'd0, 8'hC0);
    rd_now(3'd0, d); chk(d == 8'hC8, "R9 flush bit visible", d, 8'hC8);
    rd(3'd0, d); chk(d == 8'h40, "R9 flush self clears", d, 8'h40);
    rd(3'd4, d); chk(d == 8'h10, "R9 queue emptied", d, 8'h10);
    repeat (40) begin
      @(negedge clk); chk(bit_req == 1'b0, "R9 discarded not sent", bit_req, 0);
    end
    chk(rx_q.size() == 1 && rx_q[0] == 8'h11, "R9 only refused byte sent", rx_q.size(), 1);
    wr(3'd2, 8'h01);

    // R3 fill while halted
    nak_next = 1;
    wr(3'd1, 8'h99);
    wait_irq();
    for (int i = 0; i < DEPTH; i++) wr(3'd1, 8'(i));
    rd(3'd4, d); chk(d == 8'h20, "R3 full flag", d, 8'h20);
    rd(3'd2, d); chk(d[2] == 1'b0, "R3 no overflow yet", d, 8'h01);
    wr(3'd1, 8'hEE);
    rd(3'd2, d); chk(d[2] == 1'b1, "R3 overflow sticky", d, 8'h05);
    wr(3'd0, 8'h00);
    rd(3'd2, d); chk(d[2] == 1'b1, "R3 overflow stays", d, 8'h05);
    wr(3'd2, 8'h04);
    rd(3'd2, d); chk(d[2] == 1'b0, "R10 overflow cleared", d, 8'h01);
    wr(3'd0, 8'hC0);
    rd(3'd4, d); chk(d == 8'h10, "R9 flush full queue", d, 8'h10);
    wr(3'd2, 8'h07);

    // R11 masking
    rx_q.delete();
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h7E);
    wait_drained();
    rd(3'd2, d); chk(d == 8'h02, "R6 empty with mask", d, 8'h02);
    chk(irq == 1'b0, "R11 masked cause", irq, 0);
    chk(rx_q.size() == 1 && rx_q[0] == 8'h7E, "R4 single byte", rx_q.size(), 1);
    wr(3'd3, 8'h01);
    chk(irq == 1'b0, "R11 other cause only", irq, 0);
    wr(3'd3, 8'h02);
    chk(irq == 1'b1, "R11 unmask raises", irq, 1);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule